// File: doc/BRIEF.md
# Vector Configuration Unit

This unit executes the configuration step of a vector core. An issuing stage presents a requested application vector length and a proposed type word for one cycle. The unit checks the element-width and register-grouping fields of the type word and derives the largest element count a register group can hold. It stores the granted length and the accepted type in two state registers. On the next cycle it returns the granted length and a done pulse. Grouping may be an integer multiple (1, 2, 4, 8) or a fraction (1/8, 1/4, 1/2) of one register.

Encodings that are reserved or unsupported do not trap. Instead they set an illegal flag at the top bit of the stored type word. The flag also forces the granted length to zero and clears every other type field. While the flag is set, the `vinst_illegal` output tells the rest of the core to reject vector instructions, until a later configuration succeeds. A small read port serves the length, type and register-byte-count values at their fixed control-register addresses. Attempts to write those addresses change nothing.

Top module: `vcfg_unit`

## Requirements
- R1: After reset the stored length is 0, the stored type word is 0x8000_0000 (only the illegal flag set), `vinst_illegal` is 1 and `cfg_done` is 0.
- R2: A request sampled with `cfg_valid` high updates the state at that clock edge. From the following cycle `cfg_done` is 1 for one cycle and `cfg_vl` equals min(AVL, maximum element count) for a legal type.
- R3: The maximum element count is VLEN / element width × grouping. Grouping code (bits 4:2) 000/001/010/011 gives 1/2/4/8. Width code (bits 7:5) 000/001/010/011 gives 8/16/32/64 bits.
- R4: Grouping codes 101, 110 and 111 give the fractional multipliers 1/8, 1/4 and 1/2.
- R5: Grouping code 100 and width codes 100 to 111 are reserved. Either one makes the request illegal: stored type 0x8000_0000 and length 0.
- R6: A width above ELEN × grouping (ELEN = 64) is illegal. With 1/8 only 8-bit works, with 1/4 only up to 16, and with 1/2 only up to 32.
- R7: A request type word with any of bits 30:8 set, or with bit 31 set, is illegal.
- R8: For a legal request the stored type word keeps bits 7:0 as given: bit 0 is tail-agnostic, bit 1 is mask-agnostic, bits 4:2 are grouping and bits 7:5 are width. All higher bits are zero.
- R9: `vinst_illegal` equals the illegal flag of the stored type and stays set until a later legal configuration clears it.
- R10: With `csr_rd_en` high, address 0xC20 reads the length, 0xC21 reads the type word and 0xC22 reads VLEN/8, with `csr_hit` 1. Any other address, or `csr_rd_en` low, gives `csr_hit` 0 and data 0.
- R11: A write attempt (`csr_wr_en`) to 0xC20, 0xC21 or 0xC22 raises `csr_wr_err` in the same cycle and leaves length and type unchanged. Other addresses do not raise it.
- R12: With `cfg_valid` low the stored length and type hold their values and `cfg_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Configuration request strobe |
| cfg_avl | input | XLEN | Requested application vector length |
| cfg_vtype | input | XLEN | Proposed type word |
| cfg_done | output | 1 | One-cycle pulse after a request is taken |
| cfg_vl | output | XLEN | Granted (stored) vector length |
| vinst_illegal | output | 1 | Stored type is illegal; vector instructions must be rejected |
| csr_rd_en | input | 1 | Control-register read strobe |
| csr_wr_en | input | 1 | Control-register write attempt |
| csr_addr | input | 12 | Control-register address |
| csr_rdata | output | XLEN | Read data, 0 when not hit |
| csr_hit | output | 1 | Read address belongs to this unit |
| csr_wr_err | output | 1 | Write attempted to a read-only register of this unit |

## Verification
Each integer grouping is paired with a different width, so one run cannot pass by treating width and grouping as interchangeable. AVLs below, at and above the maximum count tell a true minimum apart from passing the AVL through or always granting the maximum; an AVL of zero tells a legal empty grant apart from an illegal one. The fractional legal cases sit at the boundary where the width equals ELEN × grouping, and the illegal cases sit one step over it. The remaining illegal patterns each trigger exactly one cause (reserved grouping, reserved width, a stray reserved bit, a preset flag), so each cause is tested on its own.

// File: rtl/vcfg_pkg.sv
// Package: shared field positions, encodings and helpers for the vector
// configuration unit. Assumes the type word is at least 9 bits wide.
package vcfg_pkg;

    // Field positions inside the type word (decoded by neighbours)
    localparam int TA_BIT   = 0;
    localparam int MA_BIT   = 1;
    localparam int GRP_LSB  = 2;
    localparam int WID_LSB  = 5;
    localparam int FIELD_W  = 8;

    // Read-only control-register addresses served by the unit
    localparam logic [11:0] ADDR_LEN   = 12'hC20;
    localparam logic [11:0] ADDR_TYPE  = 12'hC21;
    localparam logic [11:0] ADDR_BYTES = 12'hC22;

    // Grouping field encodings
    typedef enum logic [2:0] {
        GRP_X1   = 3'b000,
        GRP_X2   = 3'b001,
        GRP_X4   = 3'b010,
        GRP_X8   = 3'b011,
        GRP_RSV  = 3'b100,
        GRP_D8   = 3'b101,
        GRP_D4   = 3'b110,
        GRP_D2   = 3'b111
    } grp_e;

    // Base-2 logarithm of the grouping multiplier (reserved maps to 0)
    function automatic int grp_log2(input grp_e code);
        case (code)
            GRP_X1:  return 0;
            GRP_X2:  return 1;
            GRP_X4:  return 2;
            GRP_X8:  return 3;
            GRP_D8:  return -3;
            GRP_D4:  return -2;
            GRP_D2:  return -1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/vcfg_decode.sv
// Module: vcfg_decode
// Checks a proposed type word and computes the maximum element count.
// Assumes: VLEN and ELEN are powers of two, XLEN > FIELD_W, and
// VLMAX_W bits hold VLEN (largest count: 8-bit width at grouping 8).
module vcfg_decode
    import vcfg_pkg::*;
#(
    parameter int VLEN    = 512,
    parameter int ELEN    = 64,
    parameter int XLEN    = 32,
    parameter int VLMAX_W = $clog2(VLEN) + 1
) (
    input  logic [XLEN-1:0]    req_type,
    output logic               illegal,
    output logic [VLMAX_W-1:0] vlmax,
    output logic [XLEN-1:0]    type_out
);
    localparam int LOG2_VLEN = $clog2(VLEN);
    localparam int LOG2_ELEN = $clog2(ELEN);

    logic [2:0] wid_code;
    grp_e       grp_code;
    logic       rsv_bits;
    int         grp_l2;
    int         wid_l2;
    int         wid_limit;
    int         expo;

    // Field decode, legality checks and count exponent
    always_comb begin
        wid_code  = req_type[WID_LSB +: 3];
        grp_code  = grp_e'(req_type[GRP_LSB +: 3]);
        rsv_bits  = |req_type[XLEN-1:FIELD_W];
        grp_l2    = grp_log2(grp_code);
        wid_l2    = 3 + int'(wid_code);
        wid_limit = LOG2_ELEN + ((grp_l2 < 0) ? grp_l2 : 0);
        expo      = LOG2_VLEN - wid_l2 + grp_l2;
        illegal   = wid_code[2]
                  | (grp_code == GRP_RSV)
                  | rsv_bits
                  | (wid_l2 > wid_limit)
                  | (expo < 0);
    end

    // Count output, zero when the request is rejected
    always_comb begin
        if (illegal) vlmax = '0;
        else         vlmax = VLMAX_W'(1) << expo;
    end

    // Stored type word: kept low fields or the lone illegal flag
    always_comb begin
        if (illegal) type_out = {1'b1, {(XLEN-1){1'b0}}};
        else         type_out = {{(XLEN-FIELD_W){1'b0}}, req_type[FIELD_W-1:0]};
    end

endmodule

// File: rtl/vcfg_grant.sv
// Module: vcfg_grant
// Computes the granted length: min(AVL, maximum count), or zero when the
// type is illegal. Assumes VLMAX_W <= XLEN.
module vcfg_grant #(
    parameter int XLEN    = 32,
    parameter int VLMAX_W = 10
) (
    input  logic [XLEN-1:0]    avl,
    input  logic [VLMAX_W-1:0] vlmax,
    input  logic               illegal,
    output logic [XLEN-1:0]    vl
);
    logic [XLEN-1:0] vlmax_ext;

    // Widen the count to the request width for comparison
    assign vlmax_ext = {{(XLEN-VLMAX_W){1'b0}}, vlmax};

    // Select the smaller of request and capacity
    always_comb begin
        if (illegal)              vl = '0;
        else if (avl < vlmax_ext) vl = avl;
        else                      vl = vlmax_ext;
    end

endmodule

// File: rtl/vcfg_csr.sv
// Module: vcfg_csr
// Read port for the three read-only values; flags write attempts.
// Assumes the three addresses are consecutive from ADDR_LEN.
module vcfg_csr
    import vcfg_pkg::*;
#(
    parameter int VLEN = 512,
    parameter int XLEN = 32
) (
    input  logic            rd_en,
    input  logic            wr_en,
    input  logic [11:0]     addr,
    input  logic [XLEN-1:0] len_q,
    input  logic [XLEN-1:0] type_q,
    output logic [XLEN-1:0] rdata,
    output logic            hit,
    output logic            wr_err
);
    localparam int NREG = 3;

    logic [NREG-1:0] match;
    logic [XLEN-1:0] value [NREG];

    assign value[0] = len_q;
    assign value[1] = type_q;
    assign value[2] = XLEN'(VLEN / 8);

    // One address comparator per served register
    for (genvar i = 0; i < NREG; i++) begin : g_match
        assign match[i] = (addr == ADDR_LEN + 12'(i));
    end

    // Read data mux, zero on a miss
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_en && match[i]) rdata = value[i];
        end
    end

    assign hit    = rd_en & (|match);
    assign wr_err = wr_en & (|match);

endmodule

// File: rtl/vcfg_unit.sv
// Module: vcfg_unit (top)
// Executes the vector configuration step: decodes the type, grants a
// length, stores both, and serves read-only register reads.
// Assumes a single request per cycle; synchronous active-low reset.
module vcfg_unit
    import vcfg_pkg::*;
#(
    parameter int VLEN = 512,
    parameter int ELEN = 64,
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_valid,
    input  logic [XLEN-1:0] cfg_avl,
    input  logic [XLEN-1:0] cfg_vtype,
    output logic            cfg_done,
    output logic [XLEN-1:0] cfg_vl,
    output logic            vinst_illegal,
    input  logic            csr_rd_en,
    input  logic            csr_wr_en,
    input  logic [11:0]     csr_addr,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_hit,
    output logic            csr_wr_err
);
    localparam int VLMAX_W = $clog2(VLEN) + 1;
    localparam logic [XLEN-1:0] TYPE_RST = {1'b1, {(XLEN-1){1'b0}}};

    logic               dec_illegal;
    logic [VLMAX_W-1:0] dec_vlmax;
    logic [XLEN-1:0]    dec_type;
    logic [XLEN-1:0]    new_len;
    logic [XLEN-1:0]    len_q;
    logic [XLEN-1:0]    type_q;
    logic               done_q;

    vcfg_decode #(
        .VLEN(VLEN), .ELEN(ELEN), .XLEN(XLEN), .VLMAX_W(VLMAX_W)
    ) u_decode (
        .req_type (cfg_vtype),
        .illegal  (dec_illegal),
        .vlmax    (dec_vlmax),
        .type_out (dec_type)
    );

    vcfg_grant #(
        .XLEN(XLEN), .VLMAX_W(VLMAX_W)
    ) u_grant (
        .avl     (cfg_avl),
        .vlmax   (dec_vlmax),
        .illegal (dec_illegal),
        .vl      (new_len)
    );

    // State registers: length, type and the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            type_q <= TYPE_RST;
            done_q <= 1'b0;
        end else begin
            done_q <= cfg_valid;
            if (cfg_valid) begin
                len_q  <= new_len;
                type_q <= dec_type;
            end
        end
    end

    vcfg_csr #(
        .VLEN(VLEN), .XLEN(XLEN)
    ) u_csr (
        .rd_en  (csr_rd_en),
        .wr_en  (csr_wr_en),
        .addr   (csr_addr),
        .len_q  (len_q),
        .type_q (type_q),
        .rdata  (csr_rdata),
        .hit    (csr_hit),
        .wr_err (csr_wr_err)
    );

    assign cfg_done      = done_q;
    assign cfg_vl        = len_q;
    assign vinst_illegal = type_q[XLEN-1];

endmodule

// File: rtl/vcfg_checker.sv
// Module: vcfg_checker
// Port-level properties of vcfg_unit, attached by bind below.
module vcfg_checker
    import vcfg_pkg::*;
#(
    parameter int VLEN = 512,
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_valid,
    input logic [XLEN-1:0] cfg_avl,
    input logic            cfg_done,
    input logic [XLEN-1:0] cfg_vl,
    input logic            vinst_illegal,
    input logic            csr_rd_en,
    input logic            csr_wr_en,
    input logic [11:0]     csr_addr,
    input logic [XLEN-1:0] csr_rdata,
    input logic            csr_hit
);
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> cfg_done);

    p_grant_le_avl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> (cfg_vl <= $past(cfg_avl)));

    p_grant_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_vl <= XLEN'(VLEN));

    p_illegal_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vinst_illegal |-> (cfg_vl == '0));

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> ($stable(cfg_vl) && $stable(vinst_illegal) && !cfg_done));

    p_write_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr_en && !cfg_valid) |=> $stable(cfg_vl));

    p_bytes_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_hit && csr_addr == ADDR_BYTES) |-> (csr_rdata == XLEN'(VLEN / 8)));

    p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rd_en |-> (!csr_hit && csr_rdata == '0));

endmodule

bind vcfg_unit vcfg_checker #(.VLEN(VLEN), .XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_valid     (cfg_valid),
    .cfg_avl       (cfg_avl),
    .cfg_done      (cfg_done),
    .cfg_vl        (cfg_vl),
    .vinst_illegal (vinst_illegal),
    .csr_rd_en     (csr_rd_en),
    .csr_wr_en     (csr_wr_en),
    .csr_addr      (csr_addr),
    .csr_rdata     (csr_rdata),
    .csr_hit       (csr_hit)
);

// File: tb/sim_vcfg_unit.sv
// Bench for vcfg_unit: a vector table walked by one loop, then directed
// tests for reset, register reads, write attempts and hold behaviour.
module sim_vcfg_unit;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;
    localparam int NVEC = 17;

    // {avl, type in, expected length, expected stored type}
    localparam logic [127:0] VECS [NVEC] = '{
        {32'd100,        32'h0000_0000, 32'd64,  32'h0000_0000}, // R3 w8 x1
        {32'd10,         32'h0000_0001, 32'd10,  32'h0000_0001}, // R2 below max, R8 ta
        {32'd1000,       32'h0000_0024, 32'd64,  32'h0000_0024}, // R3 w16 x2
        {32'd63,         32'h0000_004A, 32'd63,  32'h0000_004A}, // R3 w32 x4, R8 ma
        {32'd64,         32'h0000_006F, 32'd64,  32'h0000_006F}, // R3 w64 x8 at max
        {32'hFFFF_FFFF,  32'h0000_000C, 32'd512, 32'h0000_000C}, // R3 w8 x8
        {32'd20,         32'h0000_0014, 32'd8,   32'h0000_0014}, // R4 w8 1/8
        {32'd5,          32'h0000_0038, 32'd5,   32'h0000_0038}, // R4 w16 1/4
        {32'd9,          32'h0000_005C, 32'd8,   32'h0000_005C}, // R4 w32 1/2
        {32'd50,         32'h0000_0034, 32'd0,   32'h8000_0000}, // R6 w16 1/8
        {32'd50,         32'h0000_007C, 32'd0,   32'h8000_0000}, // R6 w64 1/2
        {32'd50,         32'h0000_0058, 32'd0,   32'h8000_0000}, // R6 w32 1/4
        {32'd50,         32'h0000_0010, 32'd0,   32'h8000_0000}, // R5 grouping 100
        {32'd50,         32'h0000_0080, 32'd0,   32'h8000_0000}, // R5 width 100
        {32'd50,         32'h0000_0100, 32'd0,   32'h8000_0000}, // R7 bit 8
        {32'd50,         32'h8000_0000, 32'd0,   32'h8000_0000}, // R7 bit 31
        {32'd0,          32'h0000_0000, 32'd0,   32'h0000_0000}  // R2 zero AVL legal
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_valid = 1'b0;
    logic [XLEN-1:0] cfg_avl = '0;
    logic [XLEN-1:0] cfg_vtype = '0;
    logic            cfg_done;
    logic [XLEN-1:0] cfg_vl;
    logic            vinst_illegal;
    logic            csr_rd_en = 1'b0;
    logic            csr_wr_en = 1'b0;
    logic [11:0]     csr_addr = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            csr_hit;
    logic            csr_wr_err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    vcfg_unit #(.VLEN(512), .ELEN(64), .XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_avl(cfg_avl),
        .cfg_vtype(cfg_vtype), .cfg_done(cfg_done), .cfg_vl(cfg_vl),
        .vinst_illegal(vinst_illegal), .csr_rd_en(csr_rd_en),
        .csr_wr_en(csr_wr_en), .csr_addr(csr_addr), .csr_rdata(csr_rdata),
        .csr_hit(csr_hit), .csr_wr_err(csr_wr_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One request cycle; returns at the negedge after the update edge
    task automatic do_cfg(input logic [XLEN-1:0] avl, input logic [XLEN-1:0] vt);
        @(negedge clk);
        cfg_valid = 1'b1;
        cfg_avl   = avl;
        cfg_vtype = vt;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        csr_rd_en = 1'b1;
        csr_addr  = a;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 length", cfg_vl, 32'd0);
        chk("R1 illegal", 32'(vinst_illegal), 32'd1);
        chk("R1 done", 32'(cfg_done), 32'd0);
        rd(12'hC21);
        chk("R1 type", csr_rdata, 32'h8000_0000);
        csr_rd_en = 1'b0;

        // Table walk: R2..R8
        for (int i = 0; i < NVEC; i++) begin
            do_cfg(VECS[i][127:96], VECS[i][95:64]);
            chk("R2 done pulse", 32'(cfg_done), 32'd1);
            chk("R2/R3/R4 granted length", cfg_vl, VECS[i][63:32]);
            chk("R9 illegal output", 32'(vinst_illegal), 32'(VECS[i][31]));
            rd(12'hC21);
            chk("R5/R6/R7/R8 stored type", csr_rdata, VECS[i][31:0]);
            rd(12'hC20);
            chk("R10 length read", csr_rdata, VECS[i][63:32]);
            csr_rd_en = 1'b0;
            @(negedge clk);
            chk("R2 done single cycle", 32'(cfg_done), 32'd0);
        end

        // R10: byte count, miss address, disabled read
        rd(12'hC22);
        chk("R10 bytes read", csr_rdata, 32'd64);
        chk("R10 bytes hit", 32'(csr_hit), 32'd1);
        rd(12'hC23);
        chk("R10 miss hit", 32'(csr_hit), 32'd0);
        chk("R10 miss data", csr_rdata, 32'd0);
        csr_rd_en = 1'b0;
        csr_addr  = 12'hC20;
        #1;
        chk("R10 disabled hit", 32'(csr_hit), 32'd0);

        // R11: write attempts leave state unchanged
        do_cfg(32'd33, 32'h0000_0000);
        chk("R2 setup length", cfg_vl, 32'd33);
        csr_wr_en = 1'b1;
        csr_addr  = 12'hC20;
        #1;
        chk("R11 error on length", 32'(csr_wr_err), 32'd1);
        @(negedge clk);
        csr_addr = 12'hC21;
        #1;
        chk("R11 error on type", 32'(csr_wr_err), 32'd1);
        @(negedge clk);
        csr_addr = 12'h008;
        #1;
        chk("R11 no error elsewhere", 32'(csr_wr_err), 32'd0);
        @(negedge clk);
        csr_wr_en = 1'b0;
        chk("R11 length kept", cfg_vl, 32'd33);
        rd(12'hC21);
        chk("R11 type kept", csr_rdata, 32'h0000_0000);
        csr_rd_en = 1'b0;

        // R12: idle cycles hold state even with changing request inputs
        cfg_avl   = 32'd7;
        cfg_vtype = 32'h0000_0010;
        repeat (4) @(negedge clk);
        chk("R12 length hold", cfg_vl, 32'd33);
        chk("R12 no done", 32'(cfg_done), 32'd0);
        chk("R12 illegal hold", 32'(vinst_illegal), 32'd0);

        // R9: illegal persists, then clears on a legal reconfiguration
        do_cfg(32'd12, 32'h0000_0090);
        chk("R9 set", 32'(vinst_illegal), 32'd1);
        repeat (3) @(negedge clk);
        chk("R9 persists", 32'(vinst_illegal), 32'd1);
        do_cfg(32'd12, 32'h0000_0020);
        chk("R9 cleared", 32'(vinst_illegal), 32'd0);
        chk("R3 w16 x1 length", cfg_vl, 32'd12);

        // R1: reset again from a configured state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 length after reset", cfg_vl, 32'd0);
        chk("R1 illegal after reset", 32'(vinst_illegal), 32'd1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule